// File: doc/BRIEF.md
# Hybrid Thread Enqueue Dispatcher

The dispatcher stands between thread-management requests and the priority ready queue. Each request names a thread and may carry a new scheduling parameter to store first. The block keeps one 32-bit scheduling parameter for each thread ID. On every request it reads that value back and decides where the thread goes. A value below 128 marks a software thread, and the low seven bits are its priority, so the thread is offered to the ready queue through a valid/ready handshake. A value of 128 or more marks a hardware thread, and the value itself is the address of that thread's command register. In that case nothing is queued: the block becomes a bus master and writes a start command to that address.

Requests are handled one at a time. `busy` rises when a request is accepted and falls when the request completes. A single-cycle `done` pulse marks success. A single-cycle `err` pulse marks a bus write whose acknowledge did not arrive in time.

Top module: `ht_enq_dispatch`

## Requirements
- R1: After reset, `busy`, `q_valid`, `bm_valid`, `done` and `err` are all low.
- R2: If the thread's stored parameter is below 128, the block raises `q_valid` with `q_tid` set to the thread and `q_prio` set to bits 6:0 of the parameter. These outputs hold steady until a cycle with `q_ready` high. Completion is signalled by `done` in the following cycle.
- R3: If the stored parameter is 128 or more, no queue insert takes place. Instead `bm_valid` rises with `bm_addr` equal to the full 32-bit parameter and `bm_data` equal to 32'h0000_0001. `q_valid` and `bm_valid` are never high together.
- R4: While `bm_valid` is high and `bm_ack` is low, `bm_addr` and `bm_data` hold their values. A cycle with `bm_ack` high ends the write, and `done` follows one cycle later.
- R5: `bm_valid` stays high for at most 64 cycles. If `bm_ack` has not been seen by then, `bm_valid` drops and `err` pulses in the next cycle. An acknowledge in the 64th cycle still counts as success.
- R6: When `req_wr_param` is high, the parameter is stored before the type check, so the new value decides the routing of that same request.
- R7: Stored parameters are kept separately for each thread ID. A request with `req_wr_param` low is routed by the last value stored for that thread.
- R8: A request is accepted when `req_valid` is high and `busy` is low. `busy` is high from the cycle after acceptance until the cycle in which `done` or `err` is shown. A request presented while `busy` is high is ignored, and its parameter is not stored.
- R9: `done` and `err` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Enqueue request present |
| req_tid | input | 8 | Thread ID of the request |
| req_wr_param | input | 1 | Store `req_param` for this thread before routing |
| req_param | input | 32 | New scheduling parameter |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse: request completed |
| err | output | 1 | One-cycle pulse: bus write timed out |
| q_valid | output | 1 | Ready-queue insert offered |
| q_tid | output | 8 | Thread ID to insert |
| q_prio | output | 7 | Priority of the inserted thread |
| q_ready | input | 1 | Ready queue takes the insert |
| bm_valid | output | 1 | Bus-master write pending |
| bm_addr | output | 32 | Command register address |
| bm_data | output | 32 | Start command word |
| bm_ack | input | 1 | Bus accepts the write |

## Verification
Two events can fall in the same cycle: the acknowledge of a bus write and the expiry of the 64-cycle timeout. Acknowledge has priority. The bench provokes this by having its bus responder raise `bm_ack` exactly in the 64th cycle of `bm_valid`, and it expects a `done` pulse with no `err`. A later write that is never acknowledged must instead end with `err` after exactly 64 valid cycles. A second collision is also tested: a parameter write presented while a request is still in progress must be dropped. The bench judges this by enqueuing the same thread again afterwards and checking that it is still routed by its older priority.

// File: rtl/ht_enq_pkg.sv
// Package: shared types for the enqueue dispatcher.
// Assumes: nothing beyond standard SystemVerilog.
package ht_enq_pkg;

    // Dispatcher control states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for a request
        ST_LOOK = 2'd1,   // reading the stored parameter
        ST_QINS = 2'd2,   // offering the ready-queue insert
        ST_BWR  = 2'd3    // bus-master start write pending
    } disp_state_t;

endpackage

// File: rtl/ht_param_store.sv
// Module: per-thread scheduling parameter storage.
// It writes synchronously and reads combinationally, like a small RAM.
// Assumes: contents are undefined until a thread's parameter is written,
// and the caller never reads an entry it has not stored.
module ht_param_store #(
    parameter int TID_W   = 8,
    parameter int PARAM_W = 32
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [TID_W-1:0]   wr_tid,
    input  logic [PARAM_W-1:0] wr_data,
    input  logic [TID_W-1:0]   rd_tid,
    output logic [PARAM_W-1:0] rd_data
);
    localparam int NUM_THR = 1 << TID_W;

    logic [PARAM_W-1:0] mem [NUM_THR];

    // Store a new parameter for one thread
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_tid] <= wr_data;
        end
    end

    // Read the parameter of the thread being dispatched
    assign rd_data = mem[rd_tid];

endmodule

// File: rtl/ht_ack_timer.sv
// Module: counts the cycles a bus write waits for its acknowledge.
// `expired` is high during the last allowed cycle.
// Assumes: `clear` is asserted in the cycle before the waiting starts.
module ht_ack_timer #(
    parameter int TIMEOUT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(TIMEOUT + 1);

    logic [CNT_W-1:0] cnt;

    // Count cycles spent waiting without an acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Flag the final permitted waiting cycle
    assign expired = run && (cnt == CNT_W'(TIMEOUT - 1));

endmodule

// File: rtl/ht_enq_dispatch.sv
// Module: hybrid thread enqueue dispatcher (top).
// It accepts one request at a time, optionally stores a new scheduling
// parameter, then routes the thread. A parameter below 2**PRIO_W becomes
// a ready-queue insert. A larger parameter becomes a bus write of
// START_CMD to that address.
// Assumes: the ready queue and the bus hold their ready/ack inputs low
// while nothing is offered to them.
module ht_enq_dispatch #(
    parameter int          TID_W     = 8,
    parameter int          PARAM_W   = 32,
    parameter int          PRIO_W    = 7,
    parameter int          TIMEOUT   = 64,
    parameter logic [31:0] START_CMD = 32'h0000_0001
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [TID_W-1:0]   req_tid,
    input  logic               req_wr_param,
    input  logic [PARAM_W-1:0] req_param,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic               q_valid,
    output logic [TID_W-1:0]   q_tid,
    output logic [PRIO_W-1:0]  q_prio,
    input  logic               q_ready,
    output logic               bm_valid,
    output logic [PARAM_W-1:0] bm_addr,
    output logic [PARAM_W-1:0] bm_data,
    input  logic               bm_ack
);
    import ht_enq_pkg::*;

    disp_state_t        state;
    logic [TID_W-1:0]   tid_q;
    logic [PARAM_W-1:0] param_q;
    logic [PARAM_W-1:0] rd_param;
    logic               accept;
    logic               rd_is_hw;
    logic               tmo;

    assign accept = (state == ST_IDLE) && req_valid;

    // Parameter storage; a write lands at the accept edge, before the lookup
    ht_param_store #(
        .TID_W  (TID_W),
        .PARAM_W(PARAM_W)
    ) u_store (
        .clk    (clk),
        .wr_en  (accept && req_wr_param),
        .wr_tid (req_tid),
        .wr_data(req_param),
        .rd_tid (tid_q),
        .rd_data(rd_param)
    );

    // Acknowledge timeout for the start write
    ht_ack_timer #(
        .TIMEOUT(TIMEOUT)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (state == ST_LOOK),
        .run    ((state == ST_BWR) && !bm_ack),
        .expired(tmo)
    );

    // Thread type: any bit at or above the priority field marks hardware
    assign rd_is_hw = |rd_param[PARAM_W-1:PRIO_W];

    // Request sequencing and completion pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            tid_q   <= '0;
            param_q <= '0;
            done    <= 1'b0;
            err     <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        tid_q <= req_tid;
                        state <= ST_LOOK;
                    end
                end
                ST_LOOK: begin
                    param_q <= rd_param;
                    state   <= rd_is_hw ? ST_BWR : ST_QINS;
                end
                ST_QINS: begin
                    if (q_ready) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                ST_BWR: begin
                    if (bm_ack) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else if (tmo) begin
                        state <= ST_IDLE;
                        err   <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output decode from the held request
    assign busy     = (state != ST_IDLE);
    assign q_valid  = (state == ST_QINS);
    assign q_tid    = tid_q;
    assign q_prio   = param_q[PRIO_W-1:0];
    assign bm_valid = (state == ST_BWR);
    assign bm_addr  = param_q;
    assign bm_data  = PARAM_W'(START_CMD);

endmodule

// File: rtl/ht_enq_dispatch_chk.sv
// Module: protocol checker for the dispatcher, attached by bind.
// Assumes: it observes only the top-level ports of ht_enq_dispatch.
module ht_enq_dispatch_chk #(
    parameter int TID_W   = 8,
    parameter int PARAM_W = 32,
    parameter int PRIO_W  = 7,
    parameter int TIMEOUT = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               busy,
    input logic               done,
    input logic               err,
    input logic               q_valid,
    input logic [TID_W-1:0]   q_tid,
    input logic [PRIO_W-1:0]  q_prio,
    input logic               q_ready,
    input logic               bm_valid,
    input logic [PARAM_W-1:0] bm_addr,
    input logic [PARAM_W-1:0] bm_data,
    input logic               bm_ack
);
    localparam int CNT_W = $clog2(TIMEOUT + 1);

    logic [CNT_W-1:0] vcnt;

    // Count consecutive cycles with a pending bus write
    always_ff @(posedge clk) begin
        if (!rst_n || !bm_valid) begin
            vcnt <= '0;
        end else begin
            vcnt <= vcnt + 1'b1;
        end
    end

    AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);                                   // R8
    AST_Q_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid && !q_ready) |=> (q_valid && $stable(q_tid) && $stable(q_prio))); // R2
    AST_BM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bm_valid && !bm_ack) |=> ((bm_valid && $stable(bm_addr) && $stable(bm_data)) || err)); // R4
    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        !(q_valid && bm_valid));                                          // R3
    AST_HW_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        bm_valid |-> (bm_addr >= PARAM_W'(1 << PRIO_W) && bm_data == PARAM_W'(1))); // R3
    AST_TIMEOUT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        bm_valid |-> (vcnt < CNT_W'(TIMEOUT)));                           // R5
    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));                                                  // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                  // R9

endmodule

bind ht_enq_dispatch ht_enq_dispatch_chk #(
    .TID_W  (TID_W),
    .PARAM_W(PARAM_W),
    .PRIO_W (PRIO_W),
    .TIMEOUT(TIMEOUT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .q_valid  (q_valid),
    .q_tid    (q_tid),
    .q_prio   (q_prio),
    .q_ready  (q_ready),
    .bm_valid (bm_valid),
    .bm_addr  (bm_addr),
    .bm_data  (bm_data),
    .bm_ack   (bm_ack)
);

// File: tb/ht_enq_dispatch_tb.sv
// Scoreboard bench: the driver task pushes the expected outcome of each
// request, and the monitor process pops and compares it against the ports.
module ht_enq_dispatch_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_tid = '0;
    logic        req_wr_param = 1'b0;
    logic [31:0] req_param = '0;
    logic        busy, done, err;
    logic        q_valid;
    logic [7:0]  q_tid;
    logic [6:0]  q_prio;
    logic        q_ready = 1'b0;
    logic        bm_valid;
    logic [31:0] bm_addr, bm_data;
    logic        bm_ack = 1'b0;

    int errors = 0;
    int checks = 0;

    typedef struct {
        int          kind;   // 0 queue insert, 1 bus write, 2 timeout
        int          tid;
        logic [31:0] val;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] model_param [256];
    int          q_delay = 1;
    int          ack_delay = 1;
    int          qcnt = 0;
    int          bcnt = 0;
    int          lastb = 0;
    bit          expect_done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    ht_enq_dispatch u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_tid(req_tid),
        .req_wr_param(req_wr_param), .req_param(req_param),
        .busy(busy), .done(done), .err(err),
        .q_valid(q_valid), .q_tid(q_tid), .q_prio(q_prio), .q_ready(q_ready),
        .bm_valid(bm_valid), .bm_addr(bm_addr), .bm_data(bm_data), .bm_ack(bm_ack)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Driver: issue one request and record its expected outcome
    task automatic send(input int tid, input bit wr, input logic [31:0] param,
                        input int qd, input int ad, input bit timeout);
        exp_t e;
        @(negedge clk);
        while (busy) @(negedge clk);
        q_delay   = qd;
        ack_delay = ad;
        if (wr) model_param[tid] = param;
        e.tid = tid;
        e.val = model_param[tid];
        if (model_param[tid] < 32'd128) e.kind = 0;
        else if (timeout)               e.kind = 2;
        else                            e.kind = 1;
        sb.push_back(e);
        req_valid    = 1'b1;
        req_tid      = 8'(tid);
        req_wr_param = wr;
        req_param    = param;
        @(negedge clk);
        req_valid    = 1'b0;
        req_wr_param = 1'b0;
        check(busy == 1'b1, "R8", "busy after accept", 32'(busy), 32'd1);
    endtask

    // Monitor and responders: compare at each negedge, then set ready/ack
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (expect_done) begin
                    check(done == 1'b1 && err == 1'b0, "R9", "done pulse",
                          {30'd0, err, done}, 32'd1);
                    expect_done = 1'b0;
                end
                if (err) begin
                    if (sb.size() == 0) begin
                        check(1'b0, "R5", "unexpected err", 32'd1, 32'd0);
                    end else begin
                        e = sb.pop_front();
                        check(e.kind == 2, "R5", "err kind", 32'd2, 32'(e.kind));
                        check(lastb == 64, "R5", "valid cycles before err",
                              32'(lastb), 32'd64);
                        check(done == 1'b0, "R9", "done with err", 32'(done), 32'd0);
                    end
                end
                // queue responder
                if (q_valid) begin
                    qcnt++;
                    q_ready = (qcnt == q_delay);
                    if (q_ready) begin
                        if (sb.size() == 0) begin
                            check(1'b0, "R2", "unexpected insert", 32'(q_tid), 32'd0);
                        end else begin
                            e = sb.pop_front();
                            check(e.kind == 0, "R3", "insert kind", 32'd0, 32'(e.kind));
                            check(q_tid == 8'(e.tid), "R7", "insert tid",
                                  32'(q_tid), 32'(e.tid));
                            check(q_prio == e.val[6:0], "R2", "insert prio",
                                  32'(q_prio), 32'(e.val[6:0]));
                            expect_done = 1'b1;
                        end
                    end
                end else begin
                    qcnt = 0;
                    q_ready = 1'b0;
                end
                // bus responder
                if (bm_valid) begin
                    bcnt++;
                    bm_ack = (bcnt == ack_delay);
                    if (bm_ack) begin
                        if (sb.size() == 0) begin
                            check(1'b0, "R3", "unexpected write", bm_addr, 32'd0);
                        end else begin
                            e = sb.pop_front();
                            check(e.kind == 1, "R2", "write kind", 32'd1, 32'(e.kind));
                            check(bm_addr == e.val, "R3", "write addr", bm_addr, e.val);
                            check(bm_data == 32'd1, "R3", "write data", bm_data, 32'd1);
                            expect_done = 1'b1;
                        end
                    end
                end else begin
                    if (bcnt != 0) lastb = bcnt;
                    bcnt = 0;
                    bm_ack = 1'b0;
                end
            end
        end
    end

    task automatic run_tests();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !q_valid && !bm_valid && !done && !err, "R1", "reset outputs",
              {27'd0, busy, q_valid, bm_valid, done, err}, 32'd0);
        send(3,   1, 32'd5,          1, 1,  0);   // R2 software priority
        send(3,   0, 32'd0,          4, 1,  0);   // R7 stored value, held insert
        send(10,  1, 32'd127,        2, 1,  0);   // R2 top software priority
        send(10,  1, 32'd128,        1, 1,  0);   // R6 rewrite turns it hardware
        send(20,  1, 32'h8000_1000,  1, 5,  0);   // R4 delayed ack
        send(20,  0, 32'd0,          1, 64, 0);   // R5 ack in the last cycle
        send(20,  0, 32'd0,          1, 0,  1);   // R5 no ack at all
        // R8: request while busy must be ignored
        req_valid = 1'b1; req_tid = 8'd3; req_wr_param = 1'b1; req_param = 32'd200;
        repeat (3) @(negedge clk);
        req_valid = 1'b0; req_wr_param = 1'b0;
        send(3,   0, 32'd0,          1, 1,  0);   // R8 still priority 5
        send(255, 1, 32'd0,          3, 1,  0);   // R2 priority zero, top tid
        @(negedge clk);
        while (busy || sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R8", "scoreboard drained", 32'(sb.size()), 32'd0);
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (100000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL R8 watchdog: actual=hung expected=finished");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule